// File: doc/BRIEF.md
# Gated-Coefficient Bit-Sliced Second-Order Recursive Section

This block is a clocked second-order recursive filter section with two zeros and two poles. It never multiplies the input word by a feedforward coefficient. Instead, each bit of the two's-complement input sample drives its own one-bit slice. A slice remembers the bit for the last two accepted samples, and it forwards a coefficient or zero for each of its three taps. A binary-weighted adder merges the slice results into one wide feedforward sum. The sign slice carries negative weight.

The recursive part keeps the last two output words in word-wide registers. It takes ordinary signed products of those words with the two pole coefficients away from the feedforward sum. The total is then rounded and saturated back to the sample width.

A source presents one sample per cycle in which `in_valid` is high. Idle cycles freeze the whole filter history. The five coefficients are static inputs, and they are sampled only on cycles in which a sample is accepted.

Top module: `gated_biquad`

## Requirements
- R1: A synchronous reset (`rst` high on a clock edge) clears both output history words and every stored input bit. After reset, `out_valid` is 0 and `out_sample` is 0, and the next response starts from zero history.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and low otherwise.
- R3: On a cycle with `in_valid` low, `out_sample` keeps its value and no history advances. A later sample then gives the same result as if the idle cycles had not occurred.
- R4: The input is signed Q1.15. Bit k has weight 2^(k-15), and bit 15 has weight -1. With both pole coefficients zero, the output equals the rounded value of b0·x[n] + b1·x[n-1] + b2·x[n-2].
- R5: With nonzero pole coefficients, y[n] = round(b0·x[n] + b1·x[n-1] + b2·x[n-2] - a1·y[n-1] - a2·y[n-2]). Here y[n-1] and y[n-2] are the previous rounded outputs.
- R6: The full-precision sum has 29 fractional bits. Rounding to Q1.15 adds half an output LSB and then truncates toward minus infinity, so exact halves round upward.
- R7: A rounded result above 32767 gives 32767, and a result below -32768 gives -32768.
- R8: Coefficients are signed Q2.14 and cover [-2, 2). The extremes -32768 (value -2) and 32767 are handled exactly, before saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is accepted on this edge |
| in_sample | input | 16 | Input sample, signed Q1.15 |
| coef_b0 | input | 16 | Feedforward coefficient for the current sample, Q2.14 |
| coef_b1 | input | 16 | Feedforward coefficient for the sample one step back, Q2.14 |
| coef_b2 | input | 16 | Feedforward coefficient for the sample two steps back, Q2.14 |
| coef_a1 | input | 16 | Pole coefficient for the output one step back, Q2.14 |
| coef_a2 | input | 16 | Pole coefficient for the output two steps back, Q2.14 |
| out_valid | output | 1 | Output sample is new this cycle |
| out_sample | output | 16 | Filtered sample, signed Q1.15 |

## Verification
The properties assume that the coefficient inputs hold steady across the edge on which a sample is accepted. The unity-pass and clamp properties also assume that every coefficient other than b0 is zero when they fire. The stimulus therefore changes coefficients only during idle cycles or straight after a reset, and never alongside an asserted `in_valid`. It also drives all inputs on the falling clock edge, so each value is stable well before the rising edge that samples it.

// File: rtl/gated_biquad_pkg.sv
package gated_biquad_pkg;
    // default geometry: Q1.15 samples, Q2.14 coefficients
    localparam int SAMPLE_W  = 16;
    localparam int COEF_W    = 16;
    localparam int COEF_FRAC = 14;
    localparam int GUARD_W   = 4;
endpackage

// File: rtl/gated_biquad_slice.sv
// One input bit: two 1-bit delays, three gated coefficients, one local sum.
module gated_biquad_slice #(
    parameter int CW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 adv,
    input  logic                 bit_in,
    input  logic signed [CW-1:0] b0,
    input  logic signed [CW-1:0] b1,
    input  logic signed [CW-1:0] b2,
    output logic signed [CW+1:0] term
);
    localparam int TW = CW + 2;

    logic [1:0] tap_d, tap_q;   // [0] one step back, [1] two steps back
    logic signed [TW-1:0] g0, g1, g2;

    always_comb begin
        tap_d = tap_q;
        if (adv) begin
            tap_d = {tap_q[0], bit_in};
        end
        g0   = bit_in   ? {{2{b0[CW-1]}}, b0} : '0;
        g1   = tap_q[0] ? {{2{b1[CW-1]}}, b1} : '0;
        g2   = tap_q[1] ? {{2{b2[CW-1]}}, b2} : '0;
        term = g0 + g1 + g2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_q <= '0;
        end else begin
            tap_q <= tap_d;
        end
    end
endmodule

// File: rtl/gated_biquad_merge.sv
// Binary-weighted merge of slice sums; the top slice is the sign and subtracts.
module gated_biquad_merge #(
    parameter int N  = 16,
    parameter int TW = 18,
    parameter int AW = 36
) (
    input  logic [N-1:0][TW-1:0] terms,
    output logic signed [AW-1:0] ff_sum
);
    logic signed [AW-1:0] ext;

    always_comb begin
        ff_sum = '0;
        ext    = '0;
        for (int k = 0; k < N; k++) begin
            ext = {{(AW-TW){terms[k][TW-1]}}, terms[k]};
            ext = ext <<< k;
            if (k == N - 1) begin
                ff_sum = ff_sum - ext;
            end else begin
                ff_sum = ff_sum + ext;
            end
        end
    end
endmodule

// File: rtl/gated_biquad_recur.sv
// Pole terms, rounding to the sample width and saturation.
module gated_biquad_recur #(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int CF = 14,
    parameter int AW = 36
) (
    input  logic signed [AW-1:0] ff_sum,
    input  logic signed [CW-1:0] a1,
    input  logic signed [CW-1:0] a2,
    input  logic signed [DW-1:0] y1,
    input  logic signed [DW-1:0] y2,
    output logic signed [DW-1:0] y_next
);
    logic signed [AW-1:0] a1x, a2x, y1x, y2x, acc, half, scaled, max_v, min_v;

    always_comb begin
        a1x    = {{(AW-CW){a1[CW-1]}}, a1};
        a2x    = {{(AW-CW){a2[CW-1]}}, a2};
        y1x    = {{(AW-DW){y1[DW-1]}}, y1};
        y2x    = {{(AW-DW){y2[DW-1]}}, y2};
        acc    = ff_sum - a1x * y1x - a2x * y2x;
        half   = '0;
        half[CF-1] = 1'b1;
        scaled = (acc + half) >>> CF;
        max_v  = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
        min_v  = ~max_v;
        if (scaled > max_v) begin
            y_next = max_v[DW-1:0];
        end else if (scaled < min_v) begin
            y_next = min_v[DW-1:0];
        end else begin
            y_next = scaled[DW-1:0];
        end
    end
endmodule

// File: rtl/gated_biquad.sv
module gated_biquad
    import gated_biquad_pkg::*;
#(
    parameter int DW = SAMPLE_W,
    parameter int CW = COEF_W,
    parameter int CF = COEF_FRAC
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_sample,
    input  logic signed [CW-1:0] coef_b0,
    input  logic signed [CW-1:0] coef_b1,
    input  logic signed [CW-1:0] coef_b2,
    input  logic signed [CW-1:0] coef_a1,
    input  logic signed [CW-1:0] coef_a2,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_sample
);
    localparam int TW = CW + 2;
    localparam int AW = CW + DW + GUARD_W;

    typedef struct packed {
        logic                 vld;
        logic signed [DW-1:0] y1;
        logic signed [DW-1:0] y2;
    } fb_state_t;

    fb_state_t st_d, st_q;
    logic [DW-1:0][TW-1:0] slice_terms;
    logic signed [AW-1:0]  ff_sum;
    logic signed [DW-1:0]  y_next;

    for (genvar k = 0; k < DW; k++) begin : g_slice
        gated_biquad_slice #(.CW(CW)) u_slice (
            .clk    (clk),
            .rst    (rst),
            .adv    (in_valid),
            .bit_in (in_sample[k]),
            .b0     (coef_b0),
            .b1     (coef_b1),
            .b2     (coef_b2),
            .term   (slice_terms[k])
        );
    end

    gated_biquad_merge #(.N(DW), .TW(TW), .AW(AW)) u_merge (
        .terms  (slice_terms),
        .ff_sum (ff_sum)
    );

    gated_biquad_recur #(.DW(DW), .CW(CW), .CF(CF), .AW(AW)) u_recur (
        .ff_sum (ff_sum),
        .a1     (coef_a1),
        .a2     (coef_a2),
        .y1     (st_q.y1),
        .y2     (st_q.y2),
        .y_next (y_next)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.y1 = y_next;
            st_d.y2 = st_q.y1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign out_sample = st_q.y1;
endmodule

// File: rtl/gated_biquad_chk.sv
module gated_biquad_chk #(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int CF = 14
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic signed [DW-1:0] in_sample,
    input logic signed [CW-1:0] coef_b0,
    input logic signed [CW-1:0] coef_b1,
    input logic signed [CW-1:0] coef_b2,
    input logic signed [CW-1:0] coef_a1,
    input logic signed [CW-1:0] coef_a2,
    input logic                 out_valid,
    input logic signed [DW-1:0] out_sample
);
    logic signed [CW-1:0] unity, neg_two;
    logic signed [DW-1:0] top_pos, top_neg;
    logic others_zero;

    always_comb begin
        unity       = '0;
        unity[CF]   = 1'b1;
        neg_two     = '0;
        neg_two[CW-1] = 1'b1;
        top_pos     = {1'b0, {(DW-1){1'b1}}};
        top_neg     = ~top_pos;
        others_zero = (coef_b1 == '0) && (coef_b2 == '0)
                   && (coef_a1 == '0) && (coef_a2 == '0);
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sample == '0));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_no_valid_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_sample));

    a_r4_unity_pass: assert property (@(posedge clk) disable iff (rst)
        (in_valid && coef_b0 == unity && others_zero)
        |=> out_sample == $past(in_sample));

    a_r7_clamp_high: assert property (@(posedge clk) disable iff (rst)
        (in_valid && coef_b0 == neg_two && others_zero && in_sample == top_neg)
        |=> out_sample == top_pos);
endmodule

bind gated_biquad gated_biquad_chk #(.DW(DW), .CW(CW), .CF(CF)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .coef_b0    (coef_b0),
    .coef_b1    (coef_b1),
    .coef_b2    (coef_b2),
    .coef_a1    (coef_a1),
    .coef_a2    (coef_a2),
    .out_valid  (out_valid),
    .out_sample (out_sample)
);

// File: tb/gated_biquad_test.sv
module gated_biquad_test;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic signed [15:0] coef_b0 = '0, coef_b1 = '0, coef_b2 = '0;
    logic signed [15:0] coef_a1 = '0, coef_a2 = '0;
    logic out_valid;
    logic signed [15:0] out_sample;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    longint mx1, mx2, my1, my2;

    always #(CLK_P/2) clk = ~clk;

    gated_biquad uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .coef_b0(coef_b0), .coef_b1(coef_b1), .coef_b2(coef_b2),
        .coef_a1(coef_a1), .coef_a2(coef_a2),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint model_step(input longint x);
        longint acc, r;
        acc = longint'(coef_b0) * x + longint'(coef_b1) * mx1 + longint'(coef_b2) * mx2
            - longint'(coef_a1) * my1 - longint'(coef_a2) * my2;
        r = (acc + 8192) >>> 14;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        mx2 = mx1; mx1 = x; my2 = my1; my1 = r;
        return r;
    endfunction

    task automatic set_coefs(input int b0, input int b1, input int b2, input int a1, input int a2);
        coef_b0 = 16'(b0); coef_b1 = 16'(b1); coef_b2 = 16'(b2);
        coef_a1 = 16'(a1); coef_a2 = 16'(a2);
    endtask

    // called at a falling edge; leaves at a falling edge
    task automatic do_reset(input string req);
        rst = 1'b1; in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
        check({req, " out_valid after reset"}, longint'(out_valid), 0);
        check({req, " out_sample after reset"}, longint'(out_sample), 0);
    endtask

    task automatic push(input string req, input int x);
        longint exp;
        in_valid  = 1'b1;
        in_sample = 16'(x);
        exp = model_step(longint'(x));
        @(negedge clk);
        check({req, " out_valid"}, longint'(out_valid), 1);
        check({req, " out_sample"}, longint'(out_sample), exp);
    endtask

    task automatic idle(input string req, input int cycles);
        longint held;
        held = longint'(out_sample);
        in_valid  = 1'b0;
        in_sample = 16'h5A5A;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check({req, " out_valid idle"}, longint'(out_valid), 0);
            check({req, " out_sample held"}, longint'(out_sample), held);
        end
    endtask

    task automatic t_reset_state();
        do_reset("R1");
    endtask

    task automatic t_fir_only();
        do_reset("R1");
        set_coefs(8192, 4096, -8192, 0, 0);
        push("R4 fir", 16384);
        push("R4 fir", -32768);
        push("R4 fir", 32767);
        push("R4 fir", 1);
        push("R4 fir", -1);
        push("R6 round", 3);
        push("R6 round", -3);
        push("R4 fir", 0);
        push("R4 fir", 0);
    endtask

    task automatic t_unity();
        do_reset("R1");
        set_coefs(16384, 0, 0, 0, 0);
        push("R4 unity", -32768);
        push("R4 unity", 12345);
        push("R4 unity", -7);
    endtask

    task automatic t_recursive();
        do_reset("R1");
        set_coefs(4096, 2048, 0, -24576, 11469);
        push("R5 impulse", 16384);
        for (int i = 0; i < 20; i++) push("R5 decay", 0);
        push("R5 step", -20000);
        for (int i = 0; i < 6; i++) push("R5 step", -20000);
    endtask

    task automatic t_idle_gaps();
        do_reset("R1");
        set_coefs(6000, -9000, 5000, -8000, 3000);
        push("R3 stream", 20000);
        idle("R2 R3", 3);
        push("R3 after gap", -15000);
        idle("R3", 1);
        push("R3 after gap", 7000);
        push("R3 stream", 0);
    endtask

    task automatic t_saturate();
        do_reset("R1");
        set_coefs(32767, 0, 0, 0, 0);
        push("R7 clamp high", 32767);
        push("R7 clamp low", -32768);
        idle("R8", 1);
        set_coefs(-32768, 0, 0, 0, 0);
        push("R8 neg two high", -32768);
        push("R8 neg two", 8192);
        push("R7 clamp low", 32767);
    endtask

    task automatic t_reset_midstream();
        do_reset("R1");
        set_coefs(8000, 8000, 8000, -16000, 8000);
        push("R5 pre", 30000);
        push("R5 pre", 30000);
        do_reset("R1 mid");
        push("R1 fresh history", 0);
        push("R1 fresh history", 100);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
        repeat (3) @(negedge clk);
        t_reset_state();
        t_fir_only();
        t_unity();
        t_recursive();
        t_idle_gaps();
        t_saturate();
        t_reset_midstream();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        #(CLK_P * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule